// File: doc/BRIEF.md
# Storage Adapter Host Register Decoder

This block sits between a host register bus and the drive side of a mass-storage bus adapter. The host issues word or byte accesses to a window of word offsets. A fixed decode table sends each offset either to a register held locally in the adapter or to a numbered register in the selected drive. Forwarded accesses go out on a separate drive-register port. The local registers are:

- a primary control/status word (function and GO from the drive, interrupt enable, DONE, two address-extension bits)
- word count
- bus address
- a secondary control/status word (unit select, increment inhibit, error flags, clear)
- a data buffer
- when the extension strap is on, a 6-bit address-extension register and a third status word

The decoder enforces the rules that keep these registers consistent. A transfer command issued while the adapter is busy is refused and flagged as a program error. The address-extension bits cannot be changed while a transfer is in progress. A clear command resets the whole adapter. Byte writes are shifted or merged depending on the register they target. Writes take effect at the clock edge. Reads and the forwarding strobes are combinational in the same cycle.

Top module: `adp_reg_access`

## Requirements
- R1: The decode table maps host word offsets as follows.
  - Local registers: 0 is primary status, 1 is word count, 2 is bus address, 4 is secondary status, 9 is data buffer.
  - Forwarded: 3→5, 5→1, 6→2, 7→4, 8→7, 10→3, 11→6, and 12..31 go to drive register offset−4.
  - A read of a forwarded offset asserts drvRd with drvReg and returns drvRdata. A write asserts drvWr with drvReg.
- R2: These offsets do not decode: 34..63, and 32..33 while extStrap is 0. An access to one of them raises hostErr, returns 0, forwards nothing and changes no state.
- R3: With extStrap=1, offset 32 is the 6-bit extension register (upper 10 bits read 0). Offset 33 is status word 3: bit 6 is interrupt enable, bits 3:0 are writable, and the other bits read 0. Odd-byte writes to either register are ignored.
- R4: A write to the low half of primary status is a transfer command when bit 0 (GO) is 1 and bits 5:1 are at least 0x14. If DONE (bit 7) is clear, the command sets secondary bit 10 (program error), is not forwarded, and leaves DONE clear.
- R5: A transfer command accepted while DONE is set does three things. It forwards bits 5:0 to drive register 0, clears DONE, and clears secondary bits 15:8. Any other low-half write also forwards bits 5:0 to drive register 0.
- R6: Primary status bits 9:8 (the extension bits) are written by high-half writes only while DONE is set. Bit 6 (interrupt enable) is written by low-half writes.
- R7: Fixed read values:
  - Secondary status always reads bits 7 and 6 as 1 and bit 5 as 0.
  - Bus address bit 0 always reads 0.
  - Primary status bit 11 reads 1, and bits 13, 12 and 10 read 0.
- R8: A write whose effective data has secondary-status bit 5 set resets the adapter instead of updating the register. After the reset, DONE=1, interrupt enable=0, and all other local state is 0.
- R9: Byte-write encoding: hostByte=1 marks a byte write, the byte is in hostWdata[7:0], and hostOdd=1 selects the high byte.
  - An odd byte write to a forwarded register or to either status word presents the byte in bits 15:8 with zeros below.
  - An even byte write presents the byte in bits 7:0 with zeros above.
- R10: A byte write to word count, bus address or data buffer replaces only the addressed half and keeps the other half.
- R11: Primary status bits 9:8 always equal extension register bits 1:0. The interrupt enable read in primary bit 6 always equals status word 3 bit 6. A write to either copy updates both.
- R12: Secondary status write behaviour:
  - Writable bits are 13, 9, 4, 3 and 2:0. A byte write merges the other half of the register before masking.
  - Primary status bits 15 and 14 read 1 whenever any secondary bit 15:8 is set.
  - A primary-status write with bit 14 set clears secondary bits 15:8.
- R13: A pulse on doneSet sets DONE. Primary status bits 5:0 are read from drive register 0, which is presented on drvReg during the read. After reset DONE reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extStrap | input | 1 | 1 enables the extension and status-3 registers |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostByte | input | 1 | 1 for a byte access |
| hostOdd | input | 1 | With hostByte, selects the high byte |
| hostAddr | input | 6 | Host word offset |
| hostWdata | input | 16 | Host write data (byte in bits 7:0) |
| hostRdata | output | 16 | Host read data |
| hostErr | output | 1 | No-response indication for undecoded offsets |
| doneSet | input | 1 | End-of-transfer event that sets DONE |
| drvWr | output | 1 | Forwarded drive-register write |
| drvRd | output | 1 | Forwarded drive-register read |
| drvReg | output | 5 | Drive register number |
| drvWdata | output | 16 | Forwarded write data |
| drvRdata | input | 16 | Drive register read data |

## Verification
The assertions assume that hostWr and hostRd are never high in the same cycle. They also assume that doneSet never coincides with a write to primary status, and that byte data sits in hostWdata[7:0]. The bench only ever drives one host strobe per cycle, places byte data low, and issues doneSet pulses as separate operations with no host access in the same cycle. The random stimulus mixes word, even-byte and odd-byte accesses over the whole decoded window plus undecoded offsets. It toggles the extension strap per access, and frequent secondary-status writes exercise the clear path.

// File: rtl/adp_reg_pkg.sv
package adp_reg_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 6;
  localparam int DRV_W = 5;
  localparam int FUNC_W = 5;
  localparam int BAE_W = 6;
  localparam int IPCK_W = 4;
  localparam int TABLE_WORDS = 32;

  localparam logic [ADDR_W-1:0] OFS_CS1 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_WC  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_BA  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_CS2 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_DB  = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] OFS_BAE = ADDR_W'(TABLE_WORDS);
  localparam logic [ADDR_W-1:0] OFS_CS3 = ADDR_W'(TABLE_WORDS + 1);
  localparam logic [ADDR_W-1:0] DRV_BIAS = ADDR_W'(4);

  localparam int GO_BIT = 0;
  localparam int IE_BIT = 6;
  localparam int ERRCLR_BIT = 14;
  localparam int CLR_BIT = 5;
  localparam int PGE_BIT = 10;
  localparam logic [WORD_W-1:0] CS2_WMASK = 16'h221F;
  localparam logic [WORD_W-1:0] CS2_READY = 16'h00C0;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CS1, SEL_WC, SEL_BA, SEL_CS2, SEL_DB, SEL_BAE, SEL_CS3, SEL_DRV
  } regSel_t;

  typedef struct packed {
    regSel_t          sel;
    logic [DRV_W-1:0] drvNum;
  } mapEntry_t;

  typedef struct packed {
    regSel_t           sel;
    logic              wrLo;
    logic              wrHi;
    logic              rd;
    logic              xferGo;
    logic              xferBad;
    logic              errClr;
    logic              fullClr;
    logic [WORD_W-1:0] val;
  } strobe_t;

  function automatic mapEntry_t mapOffset(input logic [ADDR_W-1:0] ofs, input logic extOn);
    mapEntry_t m;
    m.sel = SEL_DRV;
    m.drvNum = '0;
    if (ofs == OFS_BAE) m.sel = extOn ? SEL_BAE : SEL_NONE;
    else if (ofs == OFS_CS3) m.sel = extOn ? SEL_CS3 : SEL_NONE;
    else if (ofs > OFS_CS3) m.sel = SEL_NONE;
    else begin
      case (ofs)
        OFS_CS1: m.sel = SEL_CS1;
        OFS_WC:  m.sel = SEL_WC;
        OFS_BA:  m.sel = SEL_BA;
        OFS_CS2: m.sel = SEL_CS2;
        OFS_DB:  m.sel = SEL_DB;
        ADDR_W'(3):  m.drvNum = DRV_W'(5);
        ADDR_W'(5):  m.drvNum = DRV_W'(1);
        ADDR_W'(6):  m.drvNum = DRV_W'(2);
        ADDR_W'(7):  m.drvNum = DRV_W'(4);
        ADDR_W'(8):  m.drvNum = DRV_W'(7);
        ADDR_W'(10): m.drvNum = DRV_W'(3);
        ADDR_W'(11): m.drvNum = DRV_W'(6);
        default: m.drvNum = DRV_W'(ofs - DRV_BIAS);
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/adp_reg_ctrl.sv
module adp_reg_ctrl
  import adp_reg_pkg::*;
#(
  parameter logic [FUNC_W-1:0] XFER_MIN = 5'h14
) (
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              hostByte,
  input  logic              hostOdd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWdata,
  input  logic              extStrap,
  input  logic              doneQ,
  output strobe_t           stb,
  output logic              hostErr,
  output logic              drvWr,
  output logic              drvRd,
  output logic [DRV_W-1:0]  drvReg,
  output logic [WORD_W-1:0] drvWdata
);
  mapEntry_t ent;
  logic [WORD_W-1:0] shv;
  logic [BYTE_W-1:0] byteIn;
  logic hit, isXfer, cs1Lo, wrHit;

  always_comb begin
    ent = mapOffset(hostAddr, extStrap);
    byteIn = hostWdata[BYTE_W-1:0];
    if (!hostByte) shv = hostWdata;
    else if (hostOdd) shv = {byteIn, {BYTE_W{1'b0}}};
    else shv = {{BYTE_W{1'b0}}, byteIn};
    hit = (ent.sel != SEL_NONE);
    wrHit = hostWr && hit;
    hostErr = (hostWr || hostRd) && !hit;

    stb.sel = hit ? ent.sel : SEL_NONE;
    stb.val = shv;
    stb.wrLo = wrHit && (!hostByte || !hostOdd);
    stb.wrHi = wrHit && (!hostByte || hostOdd);
    stb.rd = hostRd && hit;
    isXfer = shv[GO_BIT] && (shv[FUNC_W:1] >= XFER_MIN);
    cs1Lo = stb.wrLo && (ent.sel == SEL_CS1);
    stb.xferGo = cs1Lo && isXfer && doneQ;
    stb.xferBad = cs1Lo && isXfer && !doneQ;
    stb.errClr = wrHit && (ent.sel == SEL_CS1) && shv[ERRCLR_BIT];
    stb.fullClr = wrHit && (ent.sel == SEL_CS2) && shv[CLR_BIT];

    drvWr = (wrHit && (ent.sel == SEL_DRV)) || (cs1Lo && !stb.xferBad);
    drvRd = stb.rd && ((ent.sel == SEL_DRV) || (ent.sel == SEL_CS1));
    drvReg = ent.drvNum;
    drvWdata = (ent.sel == SEL_CS1) ? {{(WORD_W-FUNC_W-1){1'b0}}, shv[FUNC_W:0]} : shv;
  end
endmodule

// File: rtl/adp_reg_dp.sv
module adp_reg_dp
  import adp_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              doneSet,
  input  logic [WORD_W-1:0] drvRdata,
  output logic [WORD_W-1:0] hostRdata,
  output logic              doneQ
);
  logic doneR, ieR;
  logic [BAE_W-1:0]  baeR;
  logic [IPCK_W-1:0] ipckR;
  logic [WORD_W-1:0] wcR, baR, dbR, cs2R;
  logic sc;

  function automatic logic [WORD_W-1:0] laneMerge(input logic [WORD_W-1:0] old,
      input logic [WORD_W-1:0] nv, input logic lo, input logic hi);
    return {hi ? nv[WORD_W-1:BYTE_W] : old[WORD_W-1:BYTE_W],
            lo ? nv[BYTE_W-1:0] : old[BYTE_W-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneR <= 1'b1; ieR <= 1'b0; baeR <= '0; ipckR <= '0;
      wcR <= '0; baR <= '0; dbR <= '0; cs2R <= '0;
    end else if (stb.fullClr) begin
      doneR <= 1'b1; ieR <= 1'b0; baeR <= '0; ipckR <= '0;
      wcR <= '0; baR <= '0; dbR <= '0; cs2R <= '0;
    end else begin
      if (stb.xferGo) doneR <= 1'b0;
      else if (doneSet) doneR <= 1'b1;
      case (stb.sel)
        SEL_CS1: begin
          if (stb.errClr || stb.xferGo) cs2R[WORD_W-1:BYTE_W] <= '0;
          if (stb.xferBad) cs2R[PGE_BIT] <= 1'b1;
          if (stb.wrHi && doneR) baeR[1:0] <= stb.val[9:8];
          if (stb.wrLo) ieR <= stb.val[IE_BIT];
        end
        SEL_WC: wcR <= laneMerge(wcR, stb.val, stb.wrLo, stb.wrHi);
        SEL_BA: baR <= laneMerge(baR, stb.val, stb.wrLo, stb.wrHi) & ~WORD_W'(1);
        SEL_DB: dbR <= laneMerge(dbR, stb.val, stb.wrLo, stb.wrHi);
        SEL_CS2: cs2R <= (cs2R & ~CS2_WMASK) |
                         (laneMerge(cs2R, stb.val, stb.wrLo, stb.wrHi) & CS2_WMASK);
        SEL_BAE: if (stb.wrLo) baeR <= stb.val[BAE_W-1:0];
        SEL_CS3: if (stb.wrLo) begin
          ipckR <= stb.val[IPCK_W-1:0];
          ieR <= stb.val[IE_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    sc = |cs2R[WORD_W-1:BYTE_W];
    hostRdata = '0;
    if (stb.rd) begin
      case (stb.sel)
        SEL_CS1: hostRdata = {sc, sc, 1'b0, 1'b0, 1'b1, 1'b0, baeR[1:0], doneR, ieR,
                              drvRdata[FUNC_W:0]};
        SEL_WC:  hostRdata = wcR;
        SEL_BA:  hostRdata = baR;
        SEL_CS2: hostRdata = cs2R | CS2_READY;
        SEL_DB:  hostRdata = dbR;
        SEL_BAE: hostRdata = {{(WORD_W-BAE_W){1'b0}}, baeR};
        SEL_CS3: hostRdata = {{(WORD_W-IE_BIT-1){1'b0}}, ieR, {(IE_BIT-IPCK_W){1'b0}}, ipckR};
        SEL_DRV: hostRdata = drvRdata;
        default: hostRdata = '0;
      endcase
    end
  end

  assign doneQ = doneR;
endmodule

// File: rtl/adp_reg_access.sv
module adp_reg_access
  import adp_reg_pkg::*;
#(
  parameter logic [FUNC_W-1:0] XFER_MIN = 5'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extStrap,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              hostByte,
  input  logic              hostOdd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWdata,
  output logic [WORD_W-1:0] hostRdata,
  output logic              hostErr,
  input  logic              doneSet,
  output logic              drvWr,
  output logic              drvRd,
  output logic [DRV_W-1:0]  drvReg,
  output logic [WORD_W-1:0] drvWdata,
  input  logic [WORD_W-1:0] drvRdata
);
  strobe_t stb;
  logic doneQ;

  adp_reg_ctrl #(.XFER_MIN(XFER_MIN)) u_ctrl (
    .hostWr(hostWr), .hostRd(hostRd), .hostByte(hostByte), .hostOdd(hostOdd),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .extStrap(extStrap), .doneQ(doneQ),
    .stb(stb), .hostErr(hostErr), .drvWr(drvWr), .drvRd(drvRd),
    .drvReg(drvReg), .drvWdata(drvWdata)
  );

  adp_reg_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .doneSet(doneSet),
    .drvRdata(drvRdata), .hostRdata(hostRdata), .doneQ(doneQ)
  );
endmodule

// File: rtl/adp_reg_chk.sv
module adp_reg_chk
  import adp_reg_pkg::*;
#(
  parameter logic [FUNC_W-1:0] XFER_MIN = 5'h14
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWr,
  input logic              hostRd,
  input logic              hostByte,
  input logic              hostOdd,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [WORD_W-1:0] hostWdata,
  input logic [WORD_W-1:0] hostRdata,
  input logic              hostErr,
  input logic              doneSet,
  input logic              drvWr,
  input logic              drvRd,
  input logic              doneQ
);
  logic lowWr, xferCmd;
  assign lowWr = hostWr && (!hostByte || !hostOdd);
  assign xferCmd = lowWr && (hostAddr == OFS_CS1) && hostWdata[GO_BIT] &&
                   (hostWdata[FUNC_W:1] >= XFER_MIN);

  // R2: an undecoded access never reaches the drive port
  a_r2_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    hostErr |-> (!drvWr && !drvRd));

  // R4: a transfer command while busy is not forwarded
  a_r4_reject_not_fwd: assert property (@(posedge clk) disable iff (!rstN)
    (xferCmd && !doneQ) |-> !drvWr);

  // R5: an accepted transfer clears DONE on the next cycle
  a_r5_accept_clears: assert property (@(posedge clk) disable iff (!rstN)
    (xferCmd && doneQ && !doneSet) |=> !doneQ);

  // R8: the clear bit leaves DONE set
  a_r8_clear_done: assert property (@(posedge clk) disable iff (!rstN)
    (lowWr && (hostAddr == OFS_CS2) && hostWdata[CLR_BIT]) |=> doneQ);

  // R7: bus address bit 0 reads zero
  a_r7_ba_even: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && (hostAddr == OFS_BA)) |-> !hostRdata[0]);

  // R7: secondary status ready bits read one
  a_r7_cs2_ready: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && (hostAddr == OFS_CS2)) |-> (hostRdata[7:6] == 2'b11));
endmodule

bind adp_reg_access adp_reg_chk #(.XFER_MIN(XFER_MIN)) u_chk (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostByte(hostByte),
  .hostOdd(hostOdd), .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
  .hostErr(hostErr), .doneSet(doneSet), .drvWr(drvWr), .drvRd(drvRd), .doneQ(doneQ)
);

// File: tb/adp_reg_access_bench.sv
`timescale 1ns/1ps
module adp_reg_access_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extStrap = 1'b0;
  logic hostWr = 1'b0, hostRd = 1'b0, hostByte = 1'b0, hostOdd = 1'b0;
  logic [5:0] hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic hostErr;
  logic doneSet = 1'b0;
  logic drvWr, drvRd;
  logic [4:0] drvReg;
  logic [15:0] drvWdata, drvRdata;

  always #2.5 clk = ~clk;
  assign drvRdata = 16'h1230 + {11'd0, drvReg};

  adp_reg_access u_adp_reg_access (
    .clk(clk), .rstN(rstN), .extStrap(extStrap), .hostWr(hostWr), .hostRd(hostRd),
    .hostByte(hostByte), .hostOdd(hostOdd), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostErr(hostErr), .doneSet(doneSet), .drvWr(drvWr),
    .drvRd(drvRd), .drvReg(drvReg), .drvWdata(drvWdata), .drvRdata(drvRdata)
  );

  int checks = 0;
  int fails = 0;

  // reference model state
  logic [15:0] mWc, mBa, mDb, mCs2;
  logic mDone, mIe;
  logic [5:0] mBae;
  logic [3:0] mIpck;

  task automatic modelReset();
    mWc = 0; mBa = 0; mDb = 0; mCs2 = 0; mDone = 1; mIe = 0; mBae = 0; mIpck = 0;
  endtask

  // -1 undecoded, 0..27 drive register, 100+ local register
  function automatic int expMap(input int o, input logic strap);
    case (o)
      0: return 100;  1: return 101;  2: return 102;  4: return 103;  9: return 104;
      3: return 5;    5: return 1;    6: return 2;    7: return 4;    8: return 7;
      10: return 3;   11: return 6;
      32: return strap ? 105 : -1;
      33: return strap ? 106 : -1;
      default: return (o >= 12 && o <= 31) ? o - 4 : -1;
    endcase
  endfunction

  function automatic logic [15:0] expRead(input int m);
    logic sc;
    sc = |mCs2[15:8];
    case (m)
      -1:  return 16'h0000;
      100: return {sc, sc, 4'b0010, mBae[1:0], mDone, mIe, 6'h30};
      101: return mWc;
      102: return mBa;
      103: return mCs2 | 16'h00C0;
      104: return mDb;
      105: return {10'd0, mBae};
      106: return {9'd0, mIe, 2'b00, mIpck};
      default: return 16'h1230 + 16'(m);
    endcase
  endfunction

  function automatic logic [15:0] mrg(input logic [15:0] o, input logic [15:0] n,
                                      input logic lo, input logic hi);
    return {hi ? n[15:8] : o[15:8], lo ? n[7:0] : o[7:0]};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic doRead(input int o, input string tag);
    int m;
    m = expMap(o, extStrap);
    @(negedge clk);
    hostAddr = 6'(o); hostRd = 1'b1; hostWr = 1'b0;
    #1;
    check(tag, $sformatf("read data ofs %0d", o), {16'd0, hostRdata}, {16'd0, expRead(m)});
    check(tag, $sformatf("read err ofs %0d", o), {31'd0, hostErr}, {31'd0, m < 0});
    if (m >= 0 && m < 100)
      check(tag, "read drive reg", {26'd0, drvRd, drvReg}, {26'd0, 1'b1, 5'(m)});
    if (m < 0) check(tag, "undecoded read forwards", {31'd0, drvRd}, 0);
    @(posedge clk); #1 hostRd = 1'b0;
  endtask

  task automatic doWrite(input int o, input logic bm, input logic odd,
                         input logic [15:0] d, input string tag);
    int m;
    logic [15:0] sh;
    logic lo, hi, xf, fwd, d0;
    logic [4:0] eReg;
    logic [15:0] eDat;
    m = expMap(o, extStrap);
    sh = !bm ? d : (odd ? {d[7:0], 8'h00} : {8'h00, d[7:0]});
    lo = !bm || !odd;
    hi = !bm || odd;
    xf = sh[0] && (sh[5:1] >= 5'h14);
    fwd = 0; eReg = 0; eDat = 0;
    if (m >= 0 && m < 100) begin fwd = 1; eReg = 5'(m); eDat = sh; end
    else if (m == 100) begin fwd = lo && !(xf && !mDone); eDat = {10'd0, sh[5:0]}; end
    @(negedge clk);
    hostAddr = 6'(o); hostWr = 1'b1; hostRd = 1'b0; hostByte = bm; hostOdd = odd;
    hostWdata = d;
    #1;
    check(tag, $sformatf("write err ofs %0d", o), {31'd0, hostErr}, {31'd0, m < 0});
    check(tag, $sformatf("forward strobe ofs %0d", o), {31'd0, drvWr}, {31'd0, fwd});
    if (fwd) check(tag, "forward reg/data", {11'd0, drvReg, drvWdata}, {11'd0, eReg, eDat});
    // model update
    d0 = mDone;
    case (m)
      100: begin
        if (sh[14]) mCs2[15:8] = 0;
        if (hi && d0) mBae[1:0] = sh[9:8];
        if (lo) begin
          mIe = sh[6];
          if (xf && !d0) mCs2[10] = 1'b1;
          else if (xf) begin mDone = 0; mCs2[15:8] = 0; end
        end
      end
      101: mWc = mrg(mWc, sh, lo, hi);
      102: mBa = mrg(mBa, sh, lo, hi) & 16'hFFFE;
      104: mDb = mrg(mDb, sh, lo, hi);
      103: if (sh[5]) modelReset();
           else mCs2 = (mCs2 & ~16'h221F) | (mrg(mCs2, sh, lo, hi) & 16'h221F);
      105: if (lo) mBae = sh[5:0];
      106: if (lo) begin mIpck = sh[3:0]; mIe = sh[6]; end
      default: ;
    endcase
    @(posedge clk); #1 hostWr = 1'b0; hostByte = 1'b0; hostOdd = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); doneSet = 1'b1;
    @(posedge clk); #1 doneSet = 1'b0;
    mDone = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    doRead(0, "R13 reset primary status");
    check("R13", "reset primary literal", {16'd0, expRead(100)}, 32'h08B0);
    doRead(4, "R7 secondary ready bits");
    doRead(1, "R8 reset word count");
    // accepted and rejected transfer commands
    doWrite(0, 0, 0, 16'h0031, "R5 accepted transfer");
    doRead(0, "R5 done cleared");
    doWrite(0, 0, 0, 16'h0031, "R4 rejected transfer");
    doRead(4, "R4 program error flag");
    doRead(0, "R12 error summary bits");
    doWrite(0, 0, 0, 16'h0300, "R6 extension bits locked");
    doRead(0, "R6 extension bits unchanged");
    pulseDone();
    doRead(0, "R13 done set by pulse");
    doWrite(0, 0, 0, 16'h4340, "R12 error clear with extension");
    doRead(0, "R12 errors cleared");
    doRead(4, "R12 secondary errors cleared");
    extStrap = 1'b1;
    doRead(32, "R11 extension mirror");
    doRead(33, "R11 enable mirror");
    doWrite(32, 0, 0, 16'h00FE, "R3 extension write");
    doRead(0, "R11 primary follows extension");
    doRead(32, "R3 extension six bits");
    doWrite(33, 1, 1, 16'h0000, "R3 odd byte ignored");
    doRead(33, "R3 status word 3 unchanged");
    doWrite(33, 0, 0, 16'hFFFF, "R3 status word 3 write");
    doRead(33, "R3 status word 3 masked");
    doRead(0, "R11 enable mirrored back");
    doWrite(1, 0, 0, 16'h1234, "R10 word count word");
    doWrite(1, 1, 1, 16'h00AB, "R10 word count high byte");
    doWrite(1, 1, 0, 16'h00CD, "R10 word count low byte");
    doRead(1, "R10 merged word count");
    doWrite(2, 0, 0, 16'hFFFF, "R7 bus address");
    doRead(2, "R7 bus address even");
    doWrite(9, 1, 1, 16'h0077, "R10 data buffer byte");
    doRead(9, "R10 data buffer merged");
    doWrite(3, 1, 1, 16'h005A, "R9 odd byte to drive");
    doWrite(3, 1, 0, 16'h005A, "R9 even byte to drive");
    doWrite(0, 1, 1, 16'h0040, "R9 odd byte primary status");
    doRead(0, "R9 odd byte primary status");
    doRead(17, "R1 forwarded read");
    doWrite(31, 0, 0, 16'hBEEF, "R1 forwarded write");
    extStrap = 1'b0;
    doRead(32, "R2 extension absent");
    doWrite(33, 0, 0, 16'hFFFF, "R2 status word 3 absent");
    doWrite(40, 0, 0, 16'h0020, "R2 undecoded write");
    extStrap = 1'b1;
    doRead(33, "R2 state unchanged after undecoded write");
    doWrite(4, 0, 0, 16'hFFDF, "R12 secondary writable mask");
    doRead(4, "R12 secondary readback");
    doRead(0, "R12 summary from secondary");
    doWrite(4, 0, 0, 16'h0020, "R8 adapter clear");
    doRead(0, "R8 primary after clear");
    doRead(1, "R8 word count after clear");
    doRead(32, "R8 extension after clear");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int o, kind;
      logic bm, odd;
      logic [15:0] d;
      kind = int'($urandom_range(0, 99));
      o = (kind < 85) ? int'($urandom_range(0, 35)) : int'($urandom_range(0, 63));
      extStrap = ($urandom_range(0, 3) != 0);
      bm = $urandom_range(0, 1) == 1;
      odd = $urandom_range(0, 1) == 1;
      d = 16'($urandom);
      if (kind < 5) pulseDone();
      else if (kind < 50) doRead(o, "R1 random read");
      else doWrite(o, bm, odd, d, "R9 random write");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule